// File: doc/BRIEF.md
# Interleaved Bit-Plane Pixel Serializer

This block turns one fetched screen byte into a run of pixel colour indices and drives them out as a 3-bit RGB value. Three colour depths are supported: 1, 2 and 4 bits per pixel, giving 8, 4 or 2 pixels per byte. The bits of one pixel are not stored side by side. They are spread through the byte with a stride equal to the number of pixels per byte, so each pixel takes one bit from every stride group. Each pixel is held on the output for a programmable number of clocks, which sets the horizontal stretch of the display mode.

A fetch unit presents a byte with a valid strobe. The byte waits in a one-entry holding register until the next load window, marked by `load_en_i`, comes at a time when the emitter is idle. Depth and stretch are sampled at that load. A blank request forces black and pauses the pixel sequence. The colour index is reduced modulo 8 and sent straight to the colour lines.

Top module: `pixel_serializer`

## Requirements
- R1: While `rst_ni` is low, `rgb_o` is 0, no byte is held and the emitter is idle.
- R2: Depth code 0 (1 bpp) emits 8 pixels. Pixel i is bit 7−i of the byte.
- R3: Depth code 1 (2 bpp) emits 4 pixels. Pixel i has index {b[7−i], b[3−i]}, with the first named bit as the most significant.
- R4: Depth codes 2 and 3 (4 bpp) emit 2 pixels. Pixel 0 has index {b7,b5,b3,b1} and pixel 1 has index {b6,b4,b2,b0}, most significant bit first.
- R5: Stretch code s holds each pixel on `rgb_o` for 2^s consecutive non-blanked clocks.
- R6: A load happens only on a clock where `load_en_i` is high, a byte is held and the emitter is idle. Depth and stretch are sampled on that clock.
- R7: A load window that comes while pixels are still being emitted is ignored. The held byte stays held until it is loaded. A later valid strobe before that load replaces the held byte.
- R8: While `blank_i` is high, `rgb_o` is 0 on the following cycle and the pixel sequence does not advance.
- R9: When no pixels are being emitted, `rgb_o` is 0.
- R10: `rgb_o` equals the pixel index modulo 8. Bit 0 is red, bit 1 is green and bit 2 is blue. Index bit 3 is dropped.
- R11: `rgb_o` is registered. Pixel 0 appears in the cycle after the clock edge that follows the load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Fetched screen byte |
| byte_valid_i | input | 1 | Strobe that captures `byte_i` |
| depth_i | input | 2 | Colour depth code: 0 = 1 bpp, 1 = 2 bpp, 2 or 3 = 4 bpp |
| scale_i | input | SCALE_W | Stretch code s; each pixel lasts 2^s clocks |
| load_en_i | input | 1 | Load window, one clock at the start of each access period |
| blank_i | input | 1 | Blank request: force black and pause |
| rgb_o | output | 3 | Colour output {blue, green, red} |

## Verification
On a load edge the byte moves into the emitter. Its first pixel reaches `rgb_o` one edge later, and each later pixel follows after 2^s unblanked clocks. A blanked clock shows black one edge later and shifts the rest of the sequence back by one clock. The bench's reference model keeps a queue of expected colours with one entry per output clock. It fills the queue on the modelled load edge and pops one entry on each unblanked edge. `rgb_o` is compared with the popped value at the following falling edge, once the output register has settled, so every result is checked in the exact cycle it is due.

// File: rtl/pixel_ser_pkg.sv
package pixel_ser_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int RGB_W  = 3;
  localparam int PIX_W  = 3;

  typedef enum logic [1:0] {
    BPP1     = 2'd0,
    BPP2     = 2'd1,
    BPP4     = 2'd2,
    BPP4_ALT = 2'd3
  } bpp_e;

  // index of the last pixel in a byte for a given depth
  function automatic logic [PIX_W-1:0] last_pix(bpp_e d);
    case (d)
      BPP1:    last_pix = PIX_W'(7);
      BPP2:    last_pix = PIX_W'(3);
      default: last_pix = PIX_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/pixel_ser_hold.sv
module pixel_ser_hold
  import pixel_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              take_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              pending_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o    <= '0;
      pending_o <= 1'b0;
    end else if (valid_i) begin
      byte_o    <= byte_i;
      pending_o <= 1'b1;
    end else if (take_i) begin
      pending_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pixel_ser_seq.sv
module pixel_ser_seq
  import pixel_ser_pkg::*;
#(
  parameter int SCALE_W = 2,
  localparam int HOLD_W = (1 << SCALE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              pending_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  bpp_e              depth_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic              blank_i,
  output logic              take_o,
  output logic              busy_o,
  output logic [BYTE_W-1:0] shift_o,
  output bpp_e              depth_o,
  output logic [PIX_W-1:0]  pix_left_o,
  output logic [HOLD_W-1:0] hold_cnt_o
);
  logic [HOLD_W-1:0] hold_max_q;
  logic [HOLD_W-1:0] hold_max_d;

  assign take_o     = load_en_i & pending_i & ~busy_o;
  assign hold_max_d = HOLD_W'((1 << scale_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      shift_o    <= '0;
      depth_o    <= BPP1;
      pix_left_o <= '0;
      hold_cnt_o <= '0;
      hold_max_q <= '0;
    end else if (take_o) begin
      busy_o     <= 1'b1;
      shift_o    <= byte_i;
      depth_o    <= depth_i;
      pix_left_o <= last_pix(depth_i);
      hold_cnt_o <= hold_max_d;
      hold_max_q <= hold_max_d;
    end else if (busy_o && !blank_i) begin
      if (hold_cnt_o != '0) begin
        hold_cnt_o <= hold_cnt_o - 1'b1;
      end else if (pix_left_o == '0) begin
        busy_o <= 1'b0;
      end else begin
        // next pixel's bits move into the fixed tap positions
        shift_o    <= {shift_o[BYTE_W-2:0], 1'b0};
        pix_left_o <= pix_left_o - 1'b1;
        hold_cnt_o <= hold_max_q;
      end
    end
  end
endmodule

// File: rtl/pixel_ser_map.sv
module pixel_ser_map
  import pixel_ser_pkg::*;
(
  input  logic [BYTE_W-1:0] shift_i,
  input  bpp_e              depth_i,
  output logic [RGB_W-1:0]  rgb_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    case (depth_i)
      BPP1:    idx = {3'b000, shift_i[7]};
      BPP2:    idx = {2'b00, shift_i[7], shift_i[3]};
      default: idx = {shift_i[7], shift_i[5], shift_i[3], shift_i[1]};
    endcase
  end

  // fixed palette: index mod 8, bit0 red, bit1 green, bit2 blue
  assign rgb_o = idx[RGB_W-1:0];
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pixel_ser_pkg::*;
#(
  parameter int SCALE_W = 2,
  localparam int HOLD_W = (1 << SCALE_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         byte_i,
  input  logic               byte_valid_i,
  input  logic [1:0]         depth_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               load_en_i,
  input  logic               blank_i,
  output logic [2:0]         rgb_o
);
  logic [BYTE_W-1:0] held;
  logic              pending;
  logic              take;
  logic              busy;
  logic [BYTE_W-1:0] shift;
  bpp_e              depth_q;
  logic [PIX_W-1:0]  pix_left;
  logic [HOLD_W-1:0] hold_cnt;
  logic [RGB_W-1:0]  pix_rgb;

  pixel_ser_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byte_i   (byte_i),
    .valid_i  (byte_valid_i),
    .take_i   (take),
    .byte_o   (held),
    .pending_o(pending)
  );

  pixel_ser_seq #(.SCALE_W(SCALE_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_en_i (load_en_i),
    .pending_i (pending),
    .byte_i    (held),
    .depth_i   (bpp_e'(depth_i)),
    .scale_i   (scale_i),
    .blank_i   (blank_i),
    .take_o    (take),
    .busy_o    (busy),
    .shift_o   (shift),
    .depth_o   (depth_q),
    .pix_left_o(pix_left),
    .hold_cnt_o(hold_cnt)
  );

  pixel_ser_map u_map (
    .shift_i(shift),
    .depth_i(depth_q),
    .rgb_o  (pix_rgb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rgb_o <= '0;
    else if (busy && !blank_i)  rgb_o <= pix_rgb;
    else                        rgb_o <= '0;
  end
endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk #(
  parameter int HOLD_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_en_i,
  input logic              blank_i,
  input logic              byte_valid_i,
  input logic              pending,
  input logic              busy,
  input logic [2:0]        pix_left,
  input logic [HOLD_W-1:0] hold_cnt,
  input logic [2:0]        rgb_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_black_R1: assert (rgb_o == 3'd0 && !busy && !pending);
    end
  end

  assert_idle_black_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> rgb_o == 3'd0);

  assert_blank_black_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> rgb_o == 3'd0);

  assert_blank_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && busy) |=> (busy && $stable(pix_left) && $stable(hold_cnt)));

  assert_keep_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && pending && !byte_valid_i) |=> pending);

  assert_no_load_outside_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !busy) |=> !busy);

  assert_hold_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !blank_i && hold_cnt != '0) |=> hold_cnt == $past(hold_cnt) - 1'b1);
endmodule

bind pixel_serializer pixel_serializer_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_en_i   (load_en_i),
  .blank_i     (blank_i),
  .byte_valid_i(byte_valid_i),
  .pending     (pending),
  .busy        (busy),
  .pix_left    (pix_left),
  .hold_cnt    (hold_cnt),
  .rgb_o       (rgb_o)
);

// File: tb/pixel_serializer_test.sv
module pixel_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       byte_valid = 1'b0;
  logic [1:0] depth = 2'd0;
  logic [1:0] scale = 2'd0;
  logic       load_en = 1'b0;
  logic       blank = 1'b0;
  logic [2:0] rgb;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    ph = 0;

  always #2 clk = ~clk;

  pixel_serializer uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .byte_i      (byte_in),
    .byte_valid_i(byte_valid),
    .depth_i     (depth),
    .scale_i     (scale),
    .load_en_i   (load_en),
    .blank_i     (blank),
    .rgb_o       (rgb)
  );

  // reference model: queue holds one expected colour per output clock
  int         q[$];
  bit         m_pend;
  logic [7:0] m_held;
  logic [2:0] exp_rgb;
  bit         m_ld;

  function automatic int pix_index(logic [7:0] b, int d, int i);
    if (d == 0) return int'(b[7-i]);
    if (d == 1) return int'({b[7-i], b[3-i]});
    return int'({b[7-i], b[5-i], b[3-i], b[1-i]});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_pend  = 1'b0;
      m_held  = 8'h00;
      exp_rgb = 3'd0;
    end else begin
      m_ld = load_en && m_pend && (q.size() == 0);
      if (q.size() > 0 && !blank) exp_rgb = 3'(q.pop_front());
      else                        exp_rgb = 3'd0;
      if (m_ld) begin
        int d;
        int np;
        d  = (depth == 2'd0) ? 0 : (depth == 2'd1) ? 1 : 2;
        np = 8 >> d;
        for (int i = 0; i < np; i++)
          for (int r = 0; r < (1 << scale); r++)
            q.push_back(pix_index(m_held, d, i) % 8);
      end
      if (byte_valid) begin
        m_held = byte_in;
        m_pend = 1'b1;
      end else if (m_ld) begin
        m_pend = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (rgb !== exp_rgb) begin
        n_fail++;
        $display("FAIL %s: rgb_o actual %0d expected %0d at %0t", cur_req, rgb, exp_rgb, $time);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    load_en = (ph == 0);
    ph = (ph + 1) % 8;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send(logic [7:0] b);
    step();
    byte_in = b;
    byte_valid = 1'b1;
    step();
    byte_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(4);

    cur_req = "R2"; depth = 2'd0; scale = 2'd0;
    send(8'hA5); run(24);

    cur_req = "R3"; depth = 2'd1; scale = 2'd1;
    send(8'h9C); run(24);

    cur_req = "R4"; depth = 2'd2; scale = 2'd2;
    send(8'hE1); run(24);
    depth = 2'd3; scale = 2'd0;
    send(8'h5A); run(16);

    cur_req = "R5"; depth = 2'd0; scale = 2'd3;
    send(8'h81); run(80);

    cur_req = "R6"; depth = 2'd0; scale = 2'd0;
    send(8'hC3); depth = 2'd2; scale = 2'd1; run(24);

    cur_req = "R7"; depth = 2'd0; scale = 2'd3;
    send(8'hF0); run(3);
    send(8'h0F); send(8'h3C); run(150);

    cur_req = "R8"; depth = 2'd1; scale = 2'd2;
    send(8'h6B); run(6);
    blank = 1'b1; run(5);
    blank = 1'b0; run(30);

    cur_req = "R9"; run(16);

    cur_req = "R10"; depth = 2'd2; scale = 2'd0;
    send(8'hFF); run(8);
    send(8'h80); run(8);
    send(8'h22); run(8);

    cur_req = "R11"; depth = 2'd0; scale = 2'd0;
    send(8'h01); run(16);

    cur_req = "mixed";
    for (int k = 0; k < 80; k++) begin
      depth = 2'($urandom_range(0, 3));
      scale = 2'($urandom_range(0, 3));
      send(8'($urandom_range(0, 255)));
      for (int j = 0; j < 12; j++) begin
        blank = ($urandom_range(0, 5) == 0);
        step();
      end
      blank = 1'b0;
    end
    run(40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule